// File: doc/BRIEF.md
# Power Failure Status Capture Register

This block is an 8-bit status register that records three kinds of power-sequencing faults. Its state lives in the always-on resume domain and is cleared by the resume-well reset. Each of the three low bits has its own set condition and its own clear rule. The deep-sleep indication can be flagged because its asserted pulse was shorter than a selectable minimum. The processor regulator's power-good can be seen low on a real-time-clock sample. The main power-OK can fall while the system is running or in light sleep.

Software reads the register and writes it through a single-register port: a write strobe with write data, and a read data bus that shows the current value at all times. The minimum-width checker counts real-time-clock ticks while the deep-sleep signal is asserted. After the resume reset is released, the block treats the sleep signal as asserted from that moment. A deassertion that comes too soon after power returns is therefore flagged.

Top module: `pwr_fault_status_reg`

## Requirements
- R1: While the resume reset is asserted the register reads 00h. Bits 7:3 always read 0 and writes to them have no effect, so writing FFh from 00h with no fault present gives 02h.
- R2: A deep-sleep pulse during which at least the selected number of ticks were counted leaves bit 2 unchanged. A tick is counted in a cycle where the sleep input is high and the rtc_tick input is high.
- R3: The width select picks the minimum as follows: 0 gives 1 tick, 1 gives 2, 2 gives 3 and 3 gives 4. A pulse with one tick fewer than the minimum sets bit 2 in the cycle after the sleep input falls. The select value used is the one present when the sleep input falls.
- R4: After the resume reset is released, the width measurement starts at the release even though the sleep input never rose. The first deassertion of the sleep input is judged against that start.
- R5: Writing 1 to bit 2 clears it. Writing 0 to bit 2 leaves it as it was.
- R6: Bit 1 is set only in a cycle where rtc_tick is high and the synchronized regulator power-good is low. A low power-good with no tick does not set it.
- R7: Bit 1 is a plain read/write bit. A write loads bit 1 of the write data into it, so writing 0 clears it and writing 1 sets it.
- R8: Bit 0 is set on a falling edge of the synchronized power-OK that occurs while the system state is RUN (00) or LIGHT (01). A fall in DEEP (10) or OFF (11) does not set it.
- R9: Bit 0 is cleared by writing 1 to it, and in every cycle where the system state is OFF (11). Writing 0 to it has no effect.
- R10: When a hardware set and a software clear or write hit the same bit in the same cycle, the bit ends up set.
- R11: Power-good and power-OK each pass through two flip-flops before they are used. A power-good drop applied before clock edge k with the tick held high shows in bit 1 after edge k+2 and not earlier. The power-good stages reset to high and the power-OK stages reset to low, so the reset values alone never flag a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Resume-domain clock |
| rsm_rst_n | input | 1 | Resume-well reset, active low, asynchronous assert |
| rtc_tick | input | 1 | One-cycle real-time-clock sample enable |
| deep_sleep_asrt | input | 1 | Deep-sleep indication, high while asserted |
| vreg_good | input | 1 | Processor regulator power-good, asynchronous |
| main_pwr_ok | input | 1 | Main power-OK, asynchronous |
| sys_state | input | 2 | System state: 00 RUN, 01 LIGHT, 10 DEEP, 11 OFF |
| width_sel | input | 2 | Minimum sleep-width select |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_data | output | 8 | Register read data |

## Verification
The bound assertions check on every cycle that bits 2 and 0 stay set unless their own clear rule applies, and that the OFF state always empties bit 0. They also check that bit 0 cannot rise in the DEEP or OFF states, that bit 1 cannot rise without a tick or a write of 1, and that a write of 0 with no tick clears bit 1. Only the bench scenarios can show the pulse-width thresholds for each select value, the measurement window that starts at reset release, the two-stage synchronizer latency, and that a set wins over a same-cycle clear, because each of these depends on counting ticks or edges across many cycles.

// File: rtl/pwr_fault_status_reg.sv
module pwr_fault_status_reg #(
  parameter int CNT_W       = 4,
  parameter int MIN_TICKS_0 = 1,
  parameter int MIN_TICKS_1 = 2,
  parameter int MIN_TICKS_2 = 3,
  parameter int MIN_TICKS_3 = 4
) (
  input  logic       clk,
  input  logic       rsm_rst_n,
  input  logic       rtc_tick,
  input  logic       deep_sleep_asrt,
  input  logic       vreg_good,
  input  logic       main_pwr_ok,
  input  logic [1:0] sys_state,
  input  logic [1:0] width_sel,
  input  logic       reg_wr_en,
  input  logic [7:0] reg_wr_data,
  output logic [7:0] reg_rd_data
);

  localparam logic [1:0] ST_RUN   = 2'b00;
  localparam logic [1:0] ST_LIGHT = 2'b01;
  localparam logic [1:0] ST_OFF   = 2'b11;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0]       vg_sync;
  logic [2:0]       po_sync;
  logic             slp_q;
  logic             meas_on;
  logic [CNT_W-1:0] wcnt;
  logic [CNT_W-1:0] thr;
  logic             st_width, st_vreg, st_pok;
  logic             slp_rise, slp_fall;
  logic             set_width, set_vreg, set_pok;
  logic             clr_width, clr_pok;
  logic             unused_wr_hi;

  always_comb begin
    case (width_sel)
      2'd0:    thr = CNT_W'(MIN_TICKS_0);
      2'd1:    thr = CNT_W'(MIN_TICKS_1);
      2'd2:    thr = CNT_W'(MIN_TICKS_2);
      default: thr = CNT_W'(MIN_TICKS_3);
    endcase
  end

  assign slp_rise  = deep_sleep_asrt & ~slp_q;
  assign slp_fall  = ~deep_sleep_asrt & slp_q;
  assign set_width = slp_fall & meas_on & (wcnt < thr);
  assign set_vreg  = rtc_tick & ~vg_sync[1];
  assign set_pok   = po_sync[2] & ~po_sync[1] &
                     ((sys_state == ST_RUN) | (sys_state == ST_LIGHT));
  assign clr_width = reg_wr_en & reg_wr_data[2];
  assign clr_pok   = (reg_wr_en & reg_wr_data[0]) | (sys_state == ST_OFF);
  assign unused_wr_hi = ^reg_wr_data[7:3];

  always_ff @(posedge clk or negedge rsm_rst_n) begin
    if (!rsm_rst_n) begin
      vg_sync <= 2'b11;
      po_sync <= 3'b000;
    end else begin
      vg_sync <= {vg_sync[0], vreg_good};
      po_sync <= {po_sync[1:0], main_pwr_ok};
    end
  end

  always_ff @(posedge clk or negedge rsm_rst_n) begin
    if (!rsm_rst_n) begin
      slp_q   <= 1'b1;
      meas_on <= 1'b1;
      wcnt    <= '0;
    end else begin
      slp_q <= deep_sleep_asrt;
      if (slp_rise) begin
        meas_on <= 1'b1;
        wcnt    <= rtc_tick ? CNT_W'(1) : '0;
      end else begin
        if (slp_fall)
          meas_on <= 1'b0;
        if (deep_sleep_asrt & meas_on & rtc_tick & (wcnt != CNT_MAX))
          wcnt <= wcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rsm_rst_n) begin
    if (!rsm_rst_n) begin
      st_width <= 1'b0;
      st_vreg  <= 1'b0;
      st_pok   <= 1'b0;
    end else begin
      if (set_width)      st_width <= 1'b1;
      else if (clr_width) st_width <= 1'b0;

      if (set_vreg)       st_vreg <= 1'b1;
      else if (reg_wr_en) st_vreg <= reg_wr_data[1];

      if (set_pok)        st_pok <= 1'b1;
      else if (clr_pok)   st_pok <= 1'b0;
    end
  end

  assign reg_rd_data = {5'b00000, st_width, st_vreg, st_pok};

endmodule

// File: rtl/pwr_fault_status_chk.sv
module pwr_fault_status_chk (
  input logic       clk,
  input logic       rsm_rst_n,
  input logic       rtc_tick,
  input logic       reg_wr_en,
  input logic [2:0] wr_lo,
  input logic [1:0] sys_state,
  input logic [2:0] rd_lo
);

  // R5
  width_sticky_chk: assert property (@(posedge clk) disable iff (!rsm_rst_n)
    rd_lo[2] && !(reg_wr_en && wr_lo[2]) |=> rd_lo[2]);

  // R9
  pok_sticky_chk: assert property (@(posedge clk) disable iff (!rsm_rst_n)
    rd_lo[0] && !(reg_wr_en && wr_lo[0]) && (sys_state != 2'b11) |=> rd_lo[0]);

  // R9
  pok_off_clear_chk: assert property (@(posedge clk) disable iff (!rsm_rst_n)
    (sys_state == 2'b11) |=> !rd_lo[0]);

  // R8
  pok_state_gate_chk: assert property (@(posedge clk) disable iff (!rsm_rst_n)
    !rd_lo[0] && sys_state[1] |=> !rd_lo[0]);

  // R6
  vreg_needs_tick_chk: assert property (@(posedge clk) disable iff (!rsm_rst_n)
    !rd_lo[1] && !rtc_tick && !(reg_wr_en && wr_lo[1]) |=> !rd_lo[1]);

  // R7
  vreg_write_zero_chk: assert property (@(posedge clk) disable iff (!rsm_rst_n)
    reg_wr_en && !wr_lo[1] && !rtc_tick |=> !rd_lo[1]);

endmodule

bind pwr_fault_status_reg pwr_fault_status_chk u_chk (
  .clk       (clk),
  .rsm_rst_n (rsm_rst_n),
  .rtc_tick  (rtc_tick),
  .reg_wr_en (reg_wr_en),
  .wr_lo     (reg_wr_data[2:0]),
  .sys_state (sys_state),
  .rd_lo     (reg_rd_data[2:0])
);

// File: tb/pwr_fault_status_reg_tb.sv
module pwr_fault_status_reg_tb;

  logic       clk = 1'b0;
  logic       rsm_rst_n = 1'b0;
  logic       rtc_tick = 1'b0;
  logic       deep_sleep_asrt = 1'b1;
  logic       vreg_good = 1'b1;
  logic       main_pwr_ok = 1'b1;
  logic [1:0] sys_state = 2'b11;
  logic [1:0] width_sel = 2'd1;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = 8'h00;
  logic [7:0] reg_rd_data;

  always #2 clk = ~clk;

  pwr_fault_status_reg u_dut (
    .clk(clk), .rsm_rst_n(rsm_rst_n), .rtc_tick(rtc_tick),
    .deep_sleep_asrt(deep_sleep_asrt), .vreg_good(vreg_good),
    .main_pwr_ok(main_pwr_ok), .sys_state(sys_state), .width_sel(width_sel),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 0;
  string tag = "R1";

  // behavioural reference state
  bit m2, m1, m0;
  bit mvg1, mvg2, mpo1, mpo2, mpo3;
  bit msl_prev, mact;
  int mcnt, mthr;
  bit s2, s1, s0;

  always @(posedge clk or negedge rsm_rst_n) begin
    if (!rsm_rst_n) begin
      m2 = 0; m1 = 0; m0 = 0;
      mvg1 = 1; mvg2 = 1; mpo1 = 0; mpo2 = 0; mpo3 = 0;
      msl_prev = 1; mact = 1; mcnt = 0;
    end else begin
      mthr = int'(width_sel) + 1;
      s2 = msl_prev && !deep_sleep_asrt && mact && (mcnt < mthr);
      s1 = rtc_tick && !mvg2;
      s0 = mpo3 && !mpo2 && (sys_state == 2'b00 || sys_state == 2'b01);
      if (s2) m2 = 1; else if (reg_wr_en && reg_wr_data[2]) m2 = 0;
      if (s1) m1 = 1; else if (reg_wr_en) m1 = reg_wr_data[1];
      if (s0) m0 = 1; else if (sys_state == 2'b11 || (reg_wr_en && reg_wr_data[0])) m0 = 0;
      if (deep_sleep_asrt && !msl_prev) begin
        mact = 1; mcnt = rtc_tick ? 1 : 0;
      end else if (deep_sleep_asrt && mact && rtc_tick && mcnt < 15) begin
        mcnt++;
      end
      if (!deep_sleep_asrt && msl_prev) mact = 0;
      msl_prev = deep_sleep_asrt;
      mvg2 = mvg1; mvg1 = vreg_good;
      mpo3 = mpo2; mpo2 = mpo1; mpo1 = main_pwr_ok;
    end
  end

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk)
    if (rsm_rst_n && !done) check(reg_rd_data, {5'b0, m2, m1, m0}, tag);

  task automatic report();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_n(input int n);
    repeat (n) begin
      rtc_tick = 1; @(negedge clk);
      rtc_tick = 0; @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr_en = 1; reg_wr_data = d; @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic pulse(input int sel, input int ticks);
    width_sel = 2'(sel);
    deep_sleep_asrt = 1; @(negedge clk);
    tick_n(ticks);
    deep_sleep_asrt = 0; @(negedge clk);
  endtask

  initial begin
    cyc(3);
    check(reg_rd_data, 8'h00, "R1");
    rsm_rst_n = 1;
    cyc(1);

    tag = "R4";
    tick_n(1);
    deep_sleep_asrt = 0;
    cyc(2);
    check({7'b0, reg_rd_data[2]}, 8'h01, "R4");

    tag = "R5";
    wr(8'h00); cyc(1);
    check({7'b0, reg_rd_data[2]}, 8'h01, "R5");
    wr(8'h04); cyc(1);
    check({7'b0, reg_rd_data[2]}, 8'h00, "R5");

    tag = "R4";
    rsm_rst_n = 0; deep_sleep_asrt = 1; cyc(2);
    rsm_rst_n = 1;
    tick_n(2);
    deep_sleep_asrt = 0; cyc(2);
    check({7'b0, reg_rd_data[2]}, 8'h00, "R4");

    for (int sel = 0; sel < 4; sel++) begin
      tag = "R3";
      pulse(sel, sel);
      check({7'b0, reg_rd_data[2]}, 8'h01, "R3");
      wr(8'h04);
      tag = "R2";
      pulse(sel, sel + 1);
      check({7'b0, reg_rd_data[2]}, 8'h00, "R2");
    end

    sys_state = 2'b00;
    tag = "R6";
    vreg_good = 0; cyc(5);
    check({7'b0, reg_rd_data[1]}, 8'h00, "R6");
    tick_n(1);
    check({7'b0, reg_rd_data[1]}, 8'h01, "R6");
    vreg_good = 1; cyc(3);

    tag = "R7";
    wr(8'h00);
    check({7'b0, reg_rd_data[1]}, 8'h00, "R7");
    wr(8'h02);
    check({7'b0, reg_rd_data[1]}, 8'h01, "R7");
    wr(8'h00);

    tag = "R11";
    rtc_tick = 1; vreg_good = 0;
    cyc(2);
    check({7'b0, reg_rd_data[1]}, 8'h00, "R11");
    cyc(1);
    check({7'b0, reg_rd_data[1]}, 8'h01, "R11");

    tag = "R10";
    wr(8'h00);
    check({7'b0, reg_rd_data[1]}, 8'h01, "R10");
    rtc_tick = 0; vreg_good = 1; cyc(3);
    wr(8'h00);

    tag = "R8";
    main_pwr_ok = 0; cyc(4);
    check({7'b0, reg_rd_data[0]}, 8'h01, "R8");
    main_pwr_ok = 1; cyc(3);
    wr(8'h01);
    sys_state = 2'b10;
    main_pwr_ok = 0; cyc(4);
    check({7'b0, reg_rd_data[0]}, 8'h00, "R8");
    main_pwr_ok = 1; cyc(3);
    sys_state = 2'b11;
    main_pwr_ok = 0; cyc(4);
    check({7'b0, reg_rd_data[0]}, 8'h00, "R8");
    main_pwr_ok = 1; cyc(3);
    sys_state = 2'b01;
    main_pwr_ok = 0; cyc(4);
    check({7'b0, reg_rd_data[0]}, 8'h01, "R8");
    main_pwr_ok = 1; cyc(3);

    tag = "R9";
    wr(8'h00);
    check({7'b0, reg_rd_data[0]}, 8'h01, "R9");
    wr(8'h01);
    check({7'b0, reg_rd_data[0]}, 8'h00, "R9");
    main_pwr_ok = 0; cyc(4);
    main_pwr_ok = 1; cyc(3);
    check({7'b0, reg_rd_data[0]}, 8'h01, "R9");
    sys_state = 2'b11; cyc(1);
    check({7'b0, reg_rd_data[0]}, 8'h00, "R9");
    sys_state = 2'b00; cyc(1);

    tag = "R10";
    main_pwr_ok = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1; reg_wr_data = 8'h01;
    @(negedge clk);
    reg_wr_en = 0;
    check({7'b0, reg_rd_data[0]}, 8'h01, "R10");
    main_pwr_ok = 1; cyc(3);
    wr(8'h01);

    pulse(0, 0);
    deep_sleep_asrt = 1; cyc(1);
    deep_sleep_asrt = 0; reg_wr_en = 1; reg_wr_data = 8'h04;
    @(negedge clk);
    reg_wr_en = 0;
    check({7'b0, reg_rd_data[2]}, 8'h01, "R10");

    tag = "R1";
    wr(8'hFF);
    check(reg_rd_data, 8'h02, "R1");
    cyc(2);
    report();
  end

endmodule